// File: doc/BRIEF.md
# Ratiometric Single-Slope Conversion Sequencer

This block is the digital half of a single-slope integrating converter. A free-running timer drives the integrator reset. Its pulse train has a fixed period and width that conversion activity never alters, so the analog ramp is the same on every cycle. A convert request starts a conversion, which steps a three-way analog selector through three inputs in turn: the ground input, the full-scale reference and the unknown signal. For each selection the sequencer waits until the selector has settled and a fresh ramp begins. It then counts the clock cycles during which the comparator's width pulse stays high.

From the three counts the sequencer forms (Cx − Cz)·SCALE / (Cf − Cz). The subtraction removes offset drift and the division removes drift in slope and clock, both within one conversion. The quotient comes from a restoring divider that produces one bit per cycle. The answer is presented together with a one-cycle completion strobe and three status flags: span error, underrange and overrange.

Top module: `slope_conv_seq`

## Requirements
- R1: `integ_rst` is high for exactly RST_W cycles out of every PERIOD cycles, starting from reset, whether or not a conversion is running.
- R2: At most one bit of `sel` is high at any time. Switching from one input to another passes through at least DEAD_W cycles with `sel` all zero.
- R3: In every conversion the selections follow the order `sel` = 3'b001 (ground), then 3'b010 (full-scale reference), then 3'b100 (unknown input).
- R4: A phase measures only a ramp that begins on or after the cycle in which the selector output has reached the new input. A ramp already running at that point is not used.
- R5: A phase count is the number of cycles in which `width_in` is high during the measured ramp. `result` is floor((Cx − Cz)·SCALE / (Cf − Cz)) when no flag is raised, so it does not depend on a constant offset common to all three counts.
- R6: If Cf ≤ Cz, the conversion ends with `span_err` = 1 and `result` = 0.
- R7: If Cx < Cz (and R6 does not apply), the conversion ends with `under_flag` = 1 and `result` = 0.
- R8: If `width_in` is still high in the last cycle before the next reset pulse, the phase is abandoned. The conversion then ends with `over_flag` = 1 and `result` = 0, and `sel` returns to zero on the following cycle.
- R9: A `conv_req` that arrives while a conversion is in progress is ignored: it produces neither an extra completion nor any further selector activity. A request in the completion-strobe cycle itself is accepted.
- R10: `res_valid` is high for exactly one cycle per accepted request, with at most one flag set. After reset, `res_valid`, `result` and `sel` are zero and `integ_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the counting time base |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Convert request, sampled in idle |
| width_in | input | 1 | Comparator width pulse from the analog front end |
| integ_rst | output | 1 | Integrator reset drive, free-running |
| sel | output | 3 | One-hot input selector: bit 0 ground, bit 1 reference, bit 2 unknown |
| result | output | CNT_W+K_W | Scaled ratiometric result |
| res_valid | output | 1 | One-cycle completion strobe |
| span_err | output | 1 | Reference count not above ground count |
| under_flag | output | 1 | Unknown count below ground count |
| over_flag | output | 1 | Width pulse outlasted the ramp |

## Verification
Two events can fall in the same cycle: the completion strobe of one conversion and the acceptance of the next request. The bench raises `conv_req` in the very cycle `res_valid` is seen. It then expects the first result, followed by a second correct result, with the selector walking ground, reference and unknown again. In a similar way, the request offset relative to the reset pulse is swept at random, so the selector sometimes settles on the very cycle a ramp starts. Every such conversion is judged by comparing the scaled ratio with the value the bench's ramp model predicts.

// File: rtl/slope_pkg.sv
package slope_pkg;
  localparam logic [2:0] SEL_OFF   = 3'b000;
  localparam logic [2:0] SEL_ZERO  = 3'b001;
  localparam logic [2:0] SEL_FULL  = 3'b010;
  localparam logic [2:0] SEL_INPUT = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_CALC,
    ST_DIV
  } state_e;
endpackage

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int unsigned PERIOD = 600,
  parameter int unsigned RST_W  = 60,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst,
  output logic integ_rst,
  output logic ramp_start,
  output logic ramp_end
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt, cnt_n;

  assign cnt_n = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      integ_rst <= 1'b1;
    end else begin
      cnt       <= cnt_n;
      integ_rst <= (cnt_n < CW'(RST_W));
    end
  end

  // first cycle with the reset released, and the last cycle before it returns
  assign ramp_start = (cnt == CW'(RST_W));
  assign ramp_end   = (cnt == LAST);
endmodule

// File: rtl/sel_bbm.sv
module sel_bbm #(
  parameter int unsigned DEAD_W = 3,
  localparam int unsigned DCW = $clog2(DEAD_W + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] tgt,
  output logic [2:0] sel,
  output logic       settled
);
  logic [DCW-1:0] dead;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= '0;
      dead <= '0;
    end else if (sel != tgt) begin
      if (sel != '0) begin
        sel  <= '0;
        dead <= DCW'(DEAD_W);
      end else if (dead != '0) begin
        dead <= dead - 1'b1;
      end else begin
        sel <= tgt;
      end
    end else if (dead != '0) begin
      dead <= dead - 1'b1;
    end
  end

  assign settled = (sel == tgt) && (tgt != '0);
endmodule

// File: rtl/rdiv.sv
module rdiv #(
  parameter int unsigned DW = 40,
  parameter int unsigned NW = 16,
  localparam int unsigned SW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [NW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quo
);
  logic [NW-1:0] rem, den;
  logic [DW-1:0] q;
  logic [SW-1:0] steps;
  logic          run;
  logic [NW:0]   trial;

  assign trial = {rem, q[DW-1]};
  assign quo   = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den   <= '0;
      q     <= '0;
      steps <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        q     <= dividend;
        den   <= divisor;
        steps <= '0;
        run   <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den}) begin
          rem <= NW'(trial - {1'b0, den});
          q   <= {q[DW-2:0], 1'b1};
        end else begin
          rem <= trial[NW-1:0];
          q   <= {q[DW-2:0], 1'b0};
        end
        steps <= steps + 1'b1;
        if (steps == SW'(DW - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slope_conv_seq.sv
module slope_conv_seq
  import slope_pkg::*;
#(
  parameter int unsigned PERIOD = 600,
  parameter int unsigned RST_W  = 60,
  parameter int unsigned DEAD_W = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SCALE  = 10_000_000,
  localparam int unsigned K_W   = $clog2(SCALE + 1),
  localparam int unsigned RES_W = CNT_W + K_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_req,
  input  logic             width_in,
  output logic             integ_rst,
  output logic [2:0]       sel,
  output logic [RES_W-1:0] result,
  output logic             res_valid,
  output logic             span_err,
  output logic             under_flag,
  output logic             over_flag
);
  state_e           state;
  logic [2:0]       tgt;
  logic             settled, ramp_start, ramp_end;
  logic [CNT_W-1:0] cnt, cz, cf, cx;
  logic             div_start, div_done;
  logic [RES_W-1:0] dvd, div_q;

  ramp_timer #(.PERIOD(PERIOD), .RST_W(RST_W)) u_tmr (
    .clk(clk), .rst(rst), .integ_rst(integ_rst),
    .ramp_start(ramp_start), .ramp_end(ramp_end)
  );

  sel_bbm #(.DEAD_W(DEAD_W)) u_sel (
    .clk(clk), .rst(rst), .tgt(tgt), .sel(sel), .settled(settled)
  );

  assign dvd = RES_W'(cx - cz) * RES_W'(SCALE);

  rdiv #(.DW(RES_W), .NW(CNT_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .dividend(dvd),
    .divisor(cf - cz), .done(div_done), .quo(div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tgt        <= SEL_OFF;
      cnt        <= '0;
      cz         <= '0;
      cf         <= '0;
      cx         <= '0;
      div_start  <= 1'b0;
      res_valid  <= 1'b0;
      result     <= '0;
      span_err   <= 1'b0;
      under_flag <= 1'b0;
      over_flag  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      div_start <= 1'b0;
      case (state)
        ST_IDLE: if (conv_req) begin
          tgt   <= SEL_ZERO;
          state <= ST_ARM;
        end
        // wait for a ramp that starts with the new input already connected
        ST_ARM: if (settled && ramp_start) begin
          cnt   <= '0;
          state <= ST_MEAS;
        end
        ST_MEAS: begin
          if (width_in) begin
            if (ramp_end) begin
              tgt        <= SEL_OFF;
              state      <= ST_IDLE;
              res_valid  <= 1'b1;
              result     <= '0;
              span_err   <= 1'b0;
              under_flag <= 1'b0;
              over_flag  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            case (tgt)
              SEL_ZERO: begin cz <= cnt; tgt <= SEL_FULL;  state <= ST_ARM; end
              SEL_FULL: begin cf <= cnt; tgt <= SEL_INPUT; state <= ST_ARM; end
              default:  begin cx <= cnt; tgt <= SEL_OFF;   state <= ST_CALC; end
            endcase
          end
        end
        ST_CALC: begin
          if (cf <= cz || cx < cz) begin
            state      <= ST_IDLE;
            res_valid  <= 1'b1;
            result     <= '0;
            span_err   <= (cf <= cz);
            under_flag <= (cf > cz);
            over_flag  <= 1'b0;
          end else begin
            div_start <= 1'b1;
            state     <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          state      <= ST_IDLE;
          res_valid  <= 1'b1;
          result     <= div_q;
          span_err   <= 1'b0;
          under_flag <= 1'b0;
          over_flag  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slope_conv_chk.sv
module slope_conv_chk
  import slope_pkg::*;
#(
  parameter int unsigned PERIOD = 600,
  parameter int unsigned RST_W  = 60,
  parameter int unsigned DEAD_W = 3,
  parameter int unsigned RES_W  = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             integ_rst,
  input logic [2:0]       sel,
  input logic [RES_W-1:0] result,
  input logic             res_valid,
  input logic             span_err,
  input logic             under_flag,
  input logic             over_flag
);
  logic        ir_q;
  logic [31:0] since_rise, high_run, zero_run;
  logic [2:0]  sel_q, last_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q       <= 1'b1;
      since_rise <= '0;
      high_run   <= '0;
      zero_run   <= DEAD_W;
      sel_q      <= '0;
      last_sel   <= '0;
    end else begin
      ir_q       <= integ_rst;
      since_rise <= (integ_rst && !ir_q) ? 32'd1 : since_rise + 32'd1;
      high_run   <= integ_rst ? high_run + 32'd1 : 32'd0;
      zero_run   <= (sel != '0) ? 32'd0 : ((zero_run < DEAD_W) ? zero_run + 32'd1 : zero_run);
      sel_q      <= sel;
      if (sel != '0) last_sel <= sel;
    end
  end

  a_r1_period: assert property (@(posedge clk) disable iff (rst)
    (integ_rst && !ir_q) |-> since_rise == PERIOD);
  a_r1_width: assert property (@(posedge clk) disable iff (rst)
    (!integ_rst && ir_q) |-> high_run == RST_W);
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
  a_r2_break_first: assert property (@(posedge clk) disable iff (rst)
    (sel != '0 && sel_q != '0) |-> sel == sel_q);
  a_r2_dead_gap: assert property (@(posedge clk) disable iff (rst)
    (sel != '0 && sel_q == '0) |-> zero_run >= DEAD_W);
  a_r3_full_after_zero: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_FULL && sel_q == '0) |-> last_sel == SEL_ZERO);
  a_r3_input_after_full: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_INPUT && sel_q == '0) |-> last_sel == SEL_FULL);
  a_r6_span_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && span_err) |-> result == '0);
  a_r8_over_release: assert property (@(posedge clk) disable iff (rst)
    (res_valid && over_flag) |=> sel == '0);
  a_r10_single: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({span_err, under_flag, over_flag}) <= 1);
endmodule

bind slope_conv_seq slope_conv_chk #(
  .PERIOD(PERIOD), .RST_W(RST_W), .DEAD_W(DEAD_W), .RES_W(RES_W)
) u_chk (
  .clk(clk), .rst(rst), .integ_rst(integ_rst), .sel(sel), .result(result),
  .res_valid(res_valid), .span_err(span_err), .under_flag(under_flag),
  .over_flag(over_flag)
);

// File: tb/sim_slope_conv_seq.sv
module sim_slope_conv_seq;
  localparam int unsigned PERIOD = 400;
  localparam int unsigned RST_W  = 40;
  localparam int unsigned DEAD_W = 3;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned SCALE  = 10_000_000;
  localparam int unsigned RES_W  = CNT_W + $clog2(SCALE + 1);
  localparam int          L      = PERIOD - RST_W;

  logic clk = 1'b0, rst = 1'b1, conv_req = 1'b0, width_in = 1'b0;
  logic integ_rst, res_valid, span_err, under_flag, over_flag;
  logic [2:0] sel;
  logic [RES_W-1:0] result;

  int checks = 0, errors = 0;
  int wz = 10, wf = 200, wx = 100;
  int pos = 0, wlat = 1;
  int nvalid = 0, sel_active = 0;
  int bbm_viol = 0, ord_viol = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  slope_conv_seq #(.PERIOD(PERIOD), .RST_W(RST_W), .DEAD_W(DEAD_W),
                   .CNT_W(CNT_W), .SCALE(SCALE)) u0 (
    .clk(clk), .rst(rst), .conv_req(conv_req), .width_in(width_in),
    .integ_rst(integ_rst), .sel(sel), .result(result), .res_valid(res_valid),
    .span_err(span_err), .under_flag(under_flag), .over_flag(over_flag)
  );

  task automatic chk(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ramp + comparator model: width high from ramp start for wlat cycles
  always @(negedge clk) begin
    if (rst || integ_rst) begin
      pos = 0;
      width_in = 1'b0;
    end else begin
      if (pos == 0) wlat = (sel == 3'b001) ? wz : (sel == 3'b010) ? wf : (sel == 3'b100) ? wx : 1;
      width_in = (pos < wlat);
      pos++;
    end
  end

  // port monitors: reset pulse timing, selector discipline, strobe count
  bit ir_q = 1'b1, have_rise = 0;
  int since = 0, hi = 0, zgap = 100;
  logic [2:0] sel_q = '0, last_sel = '0;
  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (integ_rst) hi++;
      if (integ_rst && !ir_q) begin
        if (have_rise) chk("R1 reset period", since == PERIOD, since, PERIOD);
        have_rise = 1;
        since = 0;
        hi = 1;
      end
      if (!integ_rst && ir_q && have_rise) chk("R1 reset width", hi == RST_W, hi, RST_W);
      ir_q = integ_rst;
      if ($countones(sel) > 1) bbm_viol++;
      if (sel != 0 && sel_q != 0 && sel != sel_q) bbm_viol++;
      if (sel != 0 && sel_q == 0) begin
        if (zgap < DEAD_W) bbm_viol++;
        if (sel == 3'b010 && last_sel != 3'b001) ord_viol++;
        if (sel == 3'b100 && last_sel != 3'b010) ord_viol++;
      end
      zgap = (sel == 0) ? zgap + 1 : 0;
      if (sel != 0) begin last_sel = sel; sel_active++; end
      sel_q = sel;
      if (res_valid) nvalid++;
    end
  end

  task automatic expect_of(input int z, f, x, output longint r, output bit sp, un, ov);
    r = 0; sp = 0; un = 0; ov = 0;
    if (z >= L || f >= L || x >= L) ov = 1;
    else if (f <= z) sp = 1;
    else if (x < z) un = 1;
    else r = (longint'(x - z) * SCALE) / (f - z);
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 8 * PERIOD; i++) begin
      @(negedge clk);
      if (res_valid) begin got = 1; return; end
    end
  endtask

  task automatic judge(string tag, int z, f, x, bit got);
    longint er; bit es, eu, eo;
    expect_of(z, f, x, er, es, eu, eo);
    chk({"R10 strobe seen ", tag}, got, got, 1);
    if (!got) return;
    chk({"R4/R5 result ", tag}, result == er, result, er);
    chk({"R6 span flag ", tag}, span_err == es, span_err, es);
    chk({"R7 under flag ", tag}, under_flag == eu, under_flag, eu);
    chk({"R8 over flag ", tag}, over_flag == eo, over_flag, eo);
    @(negedge clk);
    chk({"R10 one cycle ", tag}, res_valid == 0, res_valid, 0);
    if (eo) chk({"R8 selector off ", tag}, sel == 0, sel, 0);
  endtask

  task automatic do_conv(string tag, int z, f, x, int delay);
    bit got;
    wz = z; wf = f; wx = x;
    repeat (delay) @(negedge clk);
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    wait_valid(got);
    judge(tag, z, f, x, got);
  endtask

  initial begin
    bit got;
    int n0, s0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset integ_rst", integ_rst == 1, integ_rst, 1);
    chk("R10 reset sel", sel == 0, sel, 0);
    chk("R10 reset res_valid", res_valid == 0, res_valid, 0);
    chk("R10 reset result", result == 0, result, 0);

    do_conv("nominal", 20, 300, 150, 0);
    do_conv("x equals full", 15, 250, 250, 37);
    do_conv("x equals zero", 30, 200, 30, 111);
    do_conv("under", 40, 300, 12, 5);
    do_conv("span equal", 50, 50, 100, 200);
    do_conv("span below", 80, 60, 100, 3);
    do_conv("max in range", 10, 100, L - 1, 71);
    do_conv("over on input", 10, 100, L, 19);
    do_conv("over on zero", L, 100, 50, 250);
    do_conv("over on full", 10, L + 5, 50, 333);
    do_conv("after over", 7, 321, 123, 1);

    // R9: requests during a conversion are ignored
    wz = 25; wf = 333; wx = 222;
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    repeat (300) @(negedge clk);
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    repeat (500) @(negedge clk);
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    wait_valid(got);
    judge("busy", 25, 333, 222, got);
    n0 = nvalid; s0 = sel_active;
    repeat (3 * PERIOD) @(negedge clk);
    chk("R9 no extra strobe", nvalid == n0, nvalid, n0);
    chk("R9 selector idle", sel_active == s0, sel_active, s0);

    // R9: request in the completion-strobe cycle starts a new conversion
    wz = 12; wf = 280; wx = 90;
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    wait_valid(got);
    conv_req = 1'b1;
    wz = 33; wf = 310; wx = 300;
    judge("first of pair", 12, 280, 90, got);
    conv_req = 1'b0;
    wait_valid(got);
    judge("R9 back to back", 33, 310, 300, got);

    for (int i = 0; i < 18; i++) begin
      int z, f, x;
      z = 1 + int'($urandom % 60);
      f = z + 1 + int'($urandom % (L - 2 - z));
      x = 1 + int'($urandom % (L - 1));
      do_conv("random", z, f, x, int'($urandom % PERIOD));
    end

    chk("R2 selector discipline", bbm_viol == 0, bbm_viol, 0);
    chk("R3 selection order", ord_viol == 0, ord_viol, 0);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule